// File: doc/BRIEF.md
# Multi-Context Reconfigurable Datapath Unit

This unit sits beside the execute and memory stages of a single-issue 32-bit pipeline and runs one custom instruction per cycle. Each custom instruction reads up to four 32-bit operands and produces exactly one 32-bit result. That result is computed by a linear chain of eight coarse-grain processing elements (PEs). Every PE can add, subtract, do bitwise logic, shift or multiply. It takes its two inputs from the operands, from an earlier PE in the chain, or from the constant zero.

A store of sixteen configuration contexts, each 134 bits wide, describes the routing and the operations. The issuing instruction names one context every cycle, so back-to-back instructions may use different contexts. A split index divides the chain into an early half and a late half, and pipeline registers sit between the two halves. A per-context flag chooses where the result appears: on the early result port, one cycle after issue, or on the late result port, two cycles after issue. Writing the context store is done outside this block, so the whole image is presented as an input.

Top module: `rfu_top`

## Requirements
- R1: After reset, and before any issue, `res1_v` and `res2_v` are low and `res1_d` and `res2_d` are zero.
- R2: Context k occupies `ctx_image[134*k +: 134]`. Each cycle, the context named by `ctx_id` governs the instruction issued in that cycle. The context image may change between issues. Operand k is `opnd_in[32*k +: 32]`.
- R3: PE i uses two 4-bit source selects: bits [12i+3:12i] for input A and bits [12i+7:12i+4] for input B. The codes are: 0 to 3 pick operands 0 to 3; 4 to 11 pick the output of PE (code-4), but only if that PE lies earlier in the chain, otherwise they give zero; 12 to 15 give zero.
- R4: The 4-bit operation field of PE i is at bits [12i+11:12i+8]. The codes are: 0 add, 1 subtract A-B, 2 and, 3 or, 4 xor, 5 shift left logical, 6 shift right logical, 7 shift right arithmetic (shift amount is B[4:0] for codes 5 to 7), 8 low 32 bits of the product, 9 pass A. Codes 10 to 15 give zero.
- R5: The split index is bits [98:96]. PEs 0 to split are computed in the issue cycle. Their outputs, together with the operands, are registered. PEs above the split are computed in the following cycle from those registered values.
- R6: The output select is bits [101:99], and the port flag is bit 102. If the flag is 0, `res1_v` pulses one cycle after issue, carrying the selected PE output. If the flag is 1, `res2_v` pulses two cycles after issue. A given instruction never produces a result on both ports.
- R7: An issue with `ctx_id` of 16 or more produces no valid result on either port.
- R8: Instructions issued in consecutive cycles with different contexts each complete with their own correct result.
- R9: Context bits 133 to 103 have no effect on any result.
- R10: While a result port's valid is low, its data output is zero.
- R11: A context that selects the early port and names an output PE above the split returns zero on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_v | input | 1 | Custom instruction issued this cycle |
| ctx_id | input | 5 | Context number carried in the instruction word |
| opnd_in | input | 128 | Four packed 32-bit operands |
| ctx_image | input | 2144 | Sixteen packed 134-bit contexts |
| res1_v | output | 1 | Early-port result valid |
| res1_d | output | 32 | Early-port result |
| res2_v | output | 1 | Late-port result valid |
| res2_d | output | 32 | Late-port result |

## Verification
Hand-built contexts exercise specific behaviour:
- A multiply-accumulate chain checks that a value crosses the split correctly.
- A shift/xor/pass chain held fully in the early half checks each operation code.
- Self and forward references, zero codes and unused operation codes show that illegal routing yields zero.
- An early-port context whose output PE lies past the split checks the zero result of R11.

Two contexts that differ only in their reserved bits separate R9 from real fields. Interleaved out-of-range context numbers check that such issues are suppressed, not merely ignored in data. A long random phase exercises the pipelining of R5 and R8. It issues back-to-back instructions across random contexts, splits and port flags, with corner operand values, and rewrites the contexts partway through.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  localparam int DW   = 32;
  localparam int NPE  = 8;
  localparam int NOPS = 4;
  localparam int SELW = 4;
  localparam int OPW  = 4;
  localparam int IDXW = $clog2(NPE);
  localparam int SHW  = $clog2(DW);

  localparam logic [OPW-1:0] OP_ADD  = 4'd0;
  localparam logic [OPW-1:0] OP_SUB  = 4'd1;
  localparam logic [OPW-1:0] OP_AND  = 4'd2;
  localparam logic [OPW-1:0] OP_OR   = 4'd3;
  localparam logic [OPW-1:0] OP_XOR  = 4'd4;
  localparam logic [OPW-1:0] OP_SLL  = 4'd5;
  localparam logic [OPW-1:0] OP_SRL  = 4'd6;
  localparam logic [OPW-1:0] OP_SRA  = 4'd7;
  localparam logic [OPW-1:0] OP_MUL  = 4'd8;
  localparam logic [OPW-1:0] OP_PASS = 4'd9;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [SELW-1:0] srcb;
    logic [SELW-1:0] srca;
  } pe_cfg_t;

  typedef struct packed {
    logic                late;
    logic [IDXW-1:0]     outsel;
    logic [IDXW-1:0]     split;
    pe_cfg_t [NPE-1:0]   pe;
  } ctx_t;

  localparam int CTX_USED = $bits(ctx_t);

  typedef logic [NOPS-1:0][DW-1:0] opnd_vec_t;
  typedef logic [NPE-1:0][DW-1:0]  pe_vec_t;

  // One PE operation; unused codes give zero.
  function automatic logic [DW-1:0] pe_eval(input logic [OPW-1:0] op,
                                            input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_SLL:  return a << sh;
      OP_SRL:  return a >> sh;
      OP_SRA:  return $unsigned($signed(a) >>> sh);
      OP_MUL:  return a * b;
      OP_PASS: return a;
      default: return '0;
    endcase
  endfunction

  // Source select for PE idx: operands, earlier PEs, or zero.
  function automatic logic [DW-1:0] pe_pick(input logic [SELW-1:0] sel,
                                            input int idx,
                                            input opnd_vec_t opnd,
                                            input pe_vec_t acc);
    int s;
    s = int'(sel);
    if (s < NOPS) return opnd[s];
    if (s < NOPS + NPE && (s - NOPS) < idx) return acc[s - NOPS];
    return '0;
  endfunction
endpackage

// File: rtl/rfu_ctx_store.sv
module rfu_ctx_store
  import rfu_pkg::*;
#(
  parameter int NCTX = 16,
  parameter int CTXW = 134,
  parameter int CIDW = 5
) (
  input  logic [NCTX*CTXW-1:0] image,
  input  logic [CIDW-1:0]      ctx_id,
  output ctx_t                 ctx,
  output logic                 ctx_ok
);
  assign ctx_ok = int'(ctx_id) < NCTX;

  always_comb begin
    ctx = '0;
    for (int k = 0; k < NCTX; k++)
      if (int'(ctx_id) == k) ctx = image[k*CTXW +: CTX_USED];
  end

  // Reserved context bits are deliberately left undecoded.
  logic [NCTX-1:0] rsv_unused;
  for (genvar k = 0; k < NCTX; k++) begin : g_rsv
    if (CTXW > CTX_USED) begin : g_has
      assign rsv_unused[k] = ^image[k*CTXW+CTX_USED +: CTXW-CTX_USED];
    end else begin : g_none
      assign rsv_unused[k] = 1'b0;
    end
  end
endmodule

// File: rtl/rfu_chain.sv
module rfu_chain
  import rfu_pkg::*;
#(
  parameter bit SECOND = 1'b0
) (
  input  ctx_t      ctx,
  input  opnd_vec_t opnd,
  input  pe_vec_t   held,
  output pe_vec_t   vals
);
  // PEs owned by this half are evaluated in chain order; the rest keep
  // the held value (zero for the early half, registered for the late half).
  always_comb begin
    pe_vec_t acc;
    acc = held;
    for (int i = 0; i < NPE; i++) begin
      if ((i > int'(ctx.split)) == SECOND)
        acc[i] = pe_eval(ctx.pe[i].op,
                         pe_pick(ctx.pe[i].srca, i, opnd, acc),
                         pe_pick(ctx.pe[i].srcb, i, opnd, acc));
    end
    vals = acc;
  end
endmodule

// File: rtl/rfu_top.sv
module rfu_top
  import rfu_pkg::*;
#(
  parameter  int NCTX = 16,
  parameter  int CTXW = 134,
  localparam int CIDW = $clog2(NCTX) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_v,
  input  logic [CIDW-1:0]      ctx_id,
  input  logic [NOPS*DW-1:0]   opnd_in,
  input  logic [NCTX*CTXW-1:0] ctx_image,
  output logic                 res1_v,
  output logic [DW-1:0]        res1_d,
  output logic                 res2_v,
  output logic [DW-1:0]        res2_d
);
  // Issue-cycle (early half) signals
  ctx_t      s0_ctx;
  logic      s0_ok;
  logic      s0_go;
  logic      s0_early_fire;
  logic      s0_late_fire;
  opnd_vec_t s0_opnd;
  pe_vec_t   s0_vals;

  // Registered state feeding the late half
  ctx_t      s1_ctx;
  opnd_vec_t s1_opnd;
  pe_vec_t   s1_vals;
  logic      s1_live;
  pe_vec_t   s2_vals;

  assign s0_opnd = opnd_in;

  rfu_ctx_store #(.NCTX(NCTX), .CTXW(CTXW), .CIDW(CIDW)) u_store (
    .image  (ctx_image),
    .ctx_id (ctx_id),
    .ctx    (s0_ctx),
    .ctx_ok (s0_ok)
  );

  assign s0_go         = issue_v & s0_ok;
  assign s0_early_fire = s0_go & ~s0_ctx.late;
  assign s0_late_fire  = s0_go &  s0_ctx.late;

  rfu_chain #(.SECOND(1'b0)) u_early (
    .ctx  (s0_ctx),
    .opnd (s0_opnd),
    .held ('0),
    .vals (s0_vals)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctx  <= '0;
      s1_opnd <= '0;
      s1_vals <= '0;
      s1_live <= 1'b0;
      res1_v  <= 1'b0;
      res1_d  <= '0;
    end else begin
      s1_ctx  <= s0_ctx;
      s1_opnd <= s0_opnd;
      s1_vals <= s0_vals;
      s1_live <= s0_late_fire;
      res1_v  <= s0_early_fire;
      res1_d  <= s0_early_fire ? s0_vals[s0_ctx.outsel] : '0;
    end
  end

  rfu_chain #(.SECOND(1'b1)) u_late (
    .ctx  (s1_ctx),
    .opnd (s1_opnd),
    .held (s1_vals),
    .vals (s2_vals)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res2_v <= 1'b0;
      res2_d <= '0;
    end else begin
      res2_v <= s1_live;
      res2_d <= s1_live ? s2_vals[s1_ctx.outsel] : '0;
    end
  end

  // R7: out-of-range context launches nothing on either path
  a_r7_bad_ctx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_v && int'(ctx_id) >= NCTX) |=> (!res1_v && !s1_live));

  // R6: no result appears without an issue in the previous cycle
  a_r6_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_v |=> (!res1_v && !s1_live));

  // R6: an instruction reporting early never also reports late
  a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    res1_v |=> !res2_v);

  // R6: a late result is always preceded by a live late-half instruction
  a_r6_late_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res2_v |-> $past(s1_live));

  // R10: idle ports carry zero data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!res1_v |-> res1_d == '0) and (!res2_v |-> res2_d == '0));
endmodule

// File: tb/rfu_top_bench.sv
module rfu_top_bench;
  localparam int NC = 16;
  localparam int CW = 134;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              issue_v = 1'b0;
  logic [4:0]        ctx_id = '0;
  logic [127:0]      opnd_in = '0;
  logic [NC*CW-1:0]  img = '0;
  logic              res1_v, res2_v;
  logic [31:0]       res1_d, res2_d;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  // pending late-port expectation from the previous issue
  bit          pend_v = 1'b0;
  logic [31:0] pend_d = '0;

  always #2 clk = ~clk;

  rfu_top u_rfu_top (
    .clk(clk), .rst_n(rst_n), .issue_v(issue_v), .ctx_id(ctx_id),
    .opnd_in(opnd_in), .ctx_image(img),
    .res1_v(res1_v), .res1_d(res1_d), .res2_v(res2_v), .res2_d(res2_d)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---- behavioural reference ----
  function automatic logic [31:0] src_of(input logic [3:0] s, input int i,
                                         input logic [31:0] o [4],
                                         input logic [31:0] v [8]);
    int k;
    k = int'(s);
    if (k <= 3) return o[k];
    if (k <= 11 && (k - 4) < i) return v[k - 4];
    return 32'h0;
  endfunction

  function automatic void model(input logic [CW-1:0] c, input logic [31:0] o [4],
                                output logic [31:0] r, output bit late);
    logic [31:0] v [8];
    logic [31:0] a, b;
    int sp, os;
    for (int i = 0; i < 8; i++) v[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin
      a = src_of(c[12*i +: 4], i, o, v);
      b = src_of(c[12*i+4 +: 4], i, o, v);
      case (int'(c[12*i+8 +: 4]))
        0: v[i] = a + b;
        1: v[i] = a - b;
        2: v[i] = a & b;
        3: v[i] = a | b;
        4: v[i] = a ^ b;
        5: v[i] = a << b[4:0];
        6: v[i] = a >> b[4:0];
        7: v[i] = $unsigned($signed(a) >>> b[4:0]);
        8: v[i] = a * b;
        9: v[i] = a;
        default: v[i] = 32'h0;
      endcase
    end
    sp   = int'(c[98:96]);
    os   = int'(c[101:99]);
    late = c[102];
    r    = v[os];
    if (!late && os > sp) r = 32'h0;
  endfunction

  // ---- context builders ----
  function automatic logic [CW-1:0] put_pe(input logic [CW-1:0] c, input int i,
                                           input int sa, input int sb, input int op);
    logic [CW-1:0] t;
    t = c;
    t[12*i +: 4]   = 4'(sa);
    t[12*i+4 +: 4] = 4'(sb);
    t[12*i+8 +: 4] = 4'(op);
    return t;
  endfunction

  function automatic logic [CW-1:0] put_tail(input logic [CW-1:0] c, input int sp,
                                             input int os, input bit late);
    logic [CW-1:0] t;
    t = c;
    t[98:96]  = 3'(sp);
    t[101:99] = 3'(os);
    t[102]    = late;
    return t;
  endfunction

  function automatic logic [CW-1:0] rnd_ctx();
    logic [CW-1:0] t;
    for (int b = 0; b < CW; b++) t[b] = 1'($urandom());
    return t;
  endfunction

  function automatic logic [31:0] rnd_word();
    case ($urandom() % 6)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'($urandom() % 40);
      default: return $urandom();
    endcase
  endfunction

  // ---- one clock of stimulus and comparison ----
  task automatic cycle(input string tag, input bit iss, input int id,
                       input logic [31:0] o0, input logic [31:0] o1,
                       input logic [31:0] o2, input logic [31:0] o3);
    logic [31:0] o [4];
    logic [31:0] r;
    bit late, e1v, e2v;
    logic [31:0] e1d, e2d;
    o[0] = o0; o[1] = o1; o[2] = o2; o[3] = o3;
    @(negedge clk);
    issue_v = iss;
    ctx_id  = 5'(id);
    opnd_in = {o3, o2, o1, o0};
    e1v = 1'b0; e1d = '0; e2v = 1'b0; e2d = '0;
    if (iss && id < NC) begin
      model(img[id*CW +: CW], o, r, late);
      if (late) begin e2v = 1'b1; e2d = r; end
      else      begin e1v = 1'b1; e1d = r; end
    end
    @(posedge clk);
    #1;
    chk(tag, "res1_v", 32'(res1_v), 32'(e1v));
    chk(tag, "res1_d", res1_d, e1d);
    chk(tag, "res2_v", 32'(res2_v), 32'(pend_v));
    chk(tag, "res2_d", res2_d, pend_d);
    pend_v = e2v;
    pend_d = e2d;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [CW-1:0] c;
    // ctx0: ((o0+o1)*o2)-o3, split after PE0, late port
    c = '0;
    c = put_pe(c, 0, 0, 1, 0);
    c = put_pe(c, 1, 4, 2, 8);
    c = put_pe(c, 2, 5, 3, 1);
    c = put_tail(c, 0, 2, 1'b1);
    img[0*CW +: CW] = c;
    // ctx1: same fields, reserved bits all set (R9)
    c[CW-1:103] = '1;
    img[1*CW +: CW] = c;
    // ctx2: shift / arithmetic shift / xor / pass, all early
    c = '0;
    c = put_pe(c, 0, 0, 1, 5);
    c = put_pe(c, 1, 4, 2, 7);
    c = put_pe(c, 2, 5, 3, 4);
    c = put_pe(c, 3, 6, 13, 9);
    c = put_pe(c, 4, 7, 0, 6);
    c = put_tail(c, 7, 3, 1'b0);
    img[2*CW +: CW] = c;
    // ctx3: early port but output PE past the split (R11)
    c = '0;
    c = put_pe(c, 4, 0, 0, 0);
    c = put_tail(c, 1, 4, 1'b0);
    img[3*CW +: CW] = c;
    // ctx4: self, forward and zero references (R3)
    c = '0;
    c = put_pe(c, 0, 4, 9, 3);
    c = put_pe(c, 1, 4, 0, 3);
    c = put_pe(c, 2, 14, 5, 3);
    c = put_tail(c, 0, 2, 1'b1);
    img[4*CW +: CW] = c;
    // ctx5: unused op code
    c = '0;
    c = put_pe(c, 0, 0, 1, 12);
    c = put_pe(c, 1, 0, 1, 15);
    c = put_tail(c, 3, 1, 1'b0);
    img[5*CW +: CW] = c;
    for (int k = 6; k < NC; k++) img[k*CW +: CW] = rnd_ctx();

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "res1_v", 32'(res1_v), 32'h0);
    chk("R1", "res2_v", 32'(res2_v), 32'h0);
    chk("R1", "res1_d", res1_d, 32'h0);
    chk("R1", "res2_d", res2_d, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle("R1 R10", 1'b0, 0, 0, 0, 0, 0);

    // Directed contexts, back to back
    cycle("R2 R4 R5 R6", 1'b1, 0, 32'd3, 32'd4, 32'd5, 32'd6);
    cycle("R4 R6 R8", 1'b1, 2, 32'h8000_00F1, 32'd3, 32'd2, 32'h0F0F_0F0F);
    cycle("R9", 1'b1, 1, 32'd3, 32'd4, 32'd5, 32'd6);
    cycle("R11", 1'b1, 3, 32'd77, 32'd1, 32'd2, 32'd3);
    cycle("R3", 1'b1, 4, 32'h1234_5678, 32'h0000_00FF, 32'd9, 32'd1);
    cycle("R4", 1'b1, 5, 32'hDEAD_BEEF, 32'h1, 32'd0, 32'd0);
    cycle("R9 R8", 1'b1, 0, 32'hFFFF_FFFF, 32'd2, 32'h7, 32'd1);
    cycle("R9 R8", 1'b1, 1, 32'hFFFF_FFFF, 32'd2, 32'h7, 32'd1);
    cycle("R6 R10", 1'b0, 0, 0, 0, 0, 0);
    cycle("R6 R10", 1'b0, 0, 0, 0, 0, 0);

    // Out-of-range contexts interleaved with valid ones
    cycle("R7", 1'b1, 16, 32'd1, 32'd2, 32'd3, 32'd4);
    cycle("R7", 1'b1, 0, 32'd1, 32'd2, 32'd3, 32'd4);
    cycle("R7", 1'b1, 31, 32'd1, 32'd2, 32'd3, 32'd4);
    cycle("R7", 1'b1, 20, 32'd1, 32'd2, 32'd3, 32'd4);
    cycle("R7 R10", 1'b0, 0, 0, 0, 0, 0);
    cycle("R7 R10", 1'b0, 0, 0, 0, 0, 0);

    // Random back-to-back traffic
    for (int n = 0; n < 600; n++) begin
      if (n == 300)
        for (int k = 6; k < NC; k++) img[k*CW +: CW] = rnd_ctx();
      cycle("R2 R3 R4 R5 R6 R7 R8 R11", ($urandom() % 5) != 0,
            int'($urandom() % 20), rnd_word(), rnd_word(), rnd_word(), rnd_word());
    end
    cycle("R8 R10", 1'b0, 0, 0, 0, 0, 0);
    cycle("R8 R10", 1'b0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule